// File: doc/BRIEF.md
# Block-Count DMA Mover

This block moves whole blocks of bytes between a byte stream and a 16-bit-wide external RAM. Software programs three values through a small write-only register port: a transfer size given as a block count minus one, a RAM start position given in coarse pages, and a control word. Writing a non-zero direction code into the control word starts the move. Three directions exist. Bytes can go from the FIFO input stream into RAM, from RAM out to the FIFO output stream, or from an SD data input stream into RAM.

Bytes are paired into RAM words in arrival order. By default the earlier byte of a pair is the low half of the word, and a swap bit in the control word reverses this. Every byte stream is valid/ready. A byte moves only on a cycle where both valid and ready are high. Once the output stream raises valid, it holds its byte steady until ready is seen. The input streams may drop valid at any time. The RAM port is a request/acknowledge pair, and the engine holds the request with its address and data unchanged until the acknowledge arrives.

A stall watchdog protects the transfer. If no handshake of any kind happens for a programmable number of consecutive cycles, the engine abandons the transfer and raises a timeout flag. The flag stays set until the next start. The status word carries busy, timeout and two FIFO level bits that are passed through from outside.

Top module: `blk_dma`

## Requirements
- R1: After reset, status is 0 (with both FIFO level inputs low), and ram_req, fin_ready, sd_ready and fout_valid are all low.
- R2: A write to register select 2 (control) whose bits [1:0] are 1 (FIFO to RAM), 2 (RAM to FIFO) or 3 (SD to RAM) starts a transfer while idle, and status bit 0 (busy) reads 1 from the next cycle.
- R3: A transfer with length register value L moves exactly (L+1)*BLK_BYTES bytes, which is (L+1)*BLK_BYTES/2 RAM words. Busy then clears with the timeout flag left at 0.
- R4: The first RAM word address is the base register value times PAGE_BYTES/2. Each later RAM access uses the previous address plus one.
- R5: When writing to RAM, the word is {second byte, first byte} of each arriving pair. With control bit 2 (swap) set, the word is {first byte, second byte}. Both inbound directions behave the same way.
- R6: When reading from RAM, each word is sent low byte first and then high byte. With the swap bit set, the high byte goes first.
- R7: A byte moves only when valid and ready are both high. fout_data stays stable while fout_valid is high and fout_ready is low. Only the input stream chosen by the direction raises ready.
- R8: ram_req, ram_we, ram_addr and ram_wdata stay unchanged from the cycle ram_req rises until the cycle ram_ack is seen.
- R9: After TMO consecutive cycles with no handshake on any stream or on the RAM port (TMO is register select 3), the next cycle aborts the transfer. Busy clears, status bit 1 (timeout) sets, the flag holds while idle, and the next start clears it.
- R10: A control write while busy is ignored. The direction and byte order of the running transfer do not change.
- R11: Status bit 2 follows the tx_empty_i input and status bit 3 follows the rx_full_i input.
- R12: A control write with bits [1:0] equal to 0 does not start a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 length, 1 base, 2 control, 3 stall limit |
| reg_wdata | input | REG_W | Register write data |
| status | output | 4 | {rx full, tx empty, timeout, busy} |
| tx_empty_i | input | 1 | Transmit FIFO empty level |
| rx_full_i | input | 1 | Receive FIFO full level |
| fin_valid | input | 1 | FIFO input byte valid |
| fin_ready | output | 1 | FIFO input byte accepted |
| fin_data | input | 8 | FIFO input byte |
| sd_valid | input | 1 | SD stream byte valid |
| sd_ready | output | 1 | SD stream byte accepted |
| sd_data | input | 8 | SD stream byte |
| fout_valid | output | 1 | FIFO output byte valid |
| fout_ready | input | 1 | FIFO output can take a byte |
| fout_data | output | 8 | FIFO output byte |
| ram_req | output | 1 | RAM access request |
| ram_we | output | 1 | RAM access is a write |
| ram_addr | output | RAM_AW | RAM word address |
| ram_wdata | output | 16 | RAM write word |
| ram_ack | input | 1 | RAM access done; read word valid |
| ram_rdata | input | 16 | RAM read word |

## Verification
The bench builds the block with 8-byte blocks, 16-byte pages, a 3-bit length field, an 8-bit word address and a stall limit that resets to 40. With these values every length code from one to eight blocks can be run in all three directions and with both byte orders, all on varied base pages. This covers the whole sweep within a few thousand cycles. The small sizes also make the stall window short enough to count exactly, so the bench can show that busy is still high on the last tolerated cycle and drops one cycle later.

// File: rtl/blk_dma_pkg.sv
package blk_dma_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  localparam logic [1:0] SEL_LEN  = 2'd0;
  localparam logic [1:0] SEL_BASE = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam logic [1:0] SEL_TMO  = 2'd3;

  localparam int CTRL_SWAP_BIT = 2;

  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_F2R  = 2'd1,
    DIR_R2F  = 2'd2,
    DIR_S2R  = 2'd3
  } dma_dir_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GATHER,
    ST_WRITE,
    ST_FETCH,
    ST_EMIT
  } dma_st_e;
endpackage

// File: rtl/blk_dma_regs.sv
module blk_dma_regs
  import blk_dma_pkg::*;
#(
  parameter int REG_W       = 32,
  parameter int LEN_W       = 16,
  parameter int BASE_W      = 14,
  parameter int TMO_W       = 17,
  parameter int TMO_DEFAULT = 65536
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [REG_W-1:0]  wdata,
  input  logic              busy,
  output logic [LEN_W-1:0]  len_q,
  output logic [BASE_W-1:0] base_q,
  output logic [TMO_W-1:0]  tmo_q,
  output logic              start,
  output dma_dir_e          start_dir,
  output logic              start_swap
);
  logic unused_wdata;
  assign unused_wdata = ^wdata;

  assign start_dir  = dma_dir_e'(wdata[1:0]);
  assign start_swap = wdata[CTRL_SWAP_BIT];
  assign start      = we && (sel == SEL_CTRL) && !busy && (wdata[1:0] != 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      base_q <= '0;
      tmo_q  <= TMO_W'(TMO_DEFAULT);
    end else if (we) begin
      if (sel == SEL_LEN)  len_q  <= wdata[LEN_W-1:0];
      if (sel == SEL_BASE) base_q <= wdata[BASE_W-1:0];
      if (sel == SEL_TMO)  tmo_q  <= wdata[TMO_W-1:0];
    end
  end

  // R9: a length or limit write never changes what was latched unless addressed
  a_r9_limit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && sel == SEL_TMO) |=> $stable(tmo_q));
endmodule

// File: rtl/blk_dma_stall.sv
module blk_dma_stall #(
  parameter int TMO_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             progress,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (!active || progress) cnt_q <= '0;
    else if (cnt_q != '1)         cnt_q <= cnt_q + TMO_W'(1);
  end

  assign expired = active && !progress && (cnt_q >= limit);

  // R9: a handshake always buys at least one more cycle when the limit is non-zero
  a_r9_progress_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    (active && progress && limit != '0) |=> (!expired || limit == '0));
endmodule

// File: rtl/blk_dma_lane.sv
module blk_dma_lane
  import blk_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              swap,
  input  logic              in_fire,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              ld_word,
  input  logic [WORD_W-1:0] ld_data,
  input  logic              out_fire,
  output logic [WORD_W-1:0] word_q,
  output logic              phase_q,
  output logic [BYTE_W-1:0] out_byte
);
  logic [BYTE_W-1:0] first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      first_q <= '0;
      word_q  <= '0;
    end else if (clr) begin
      phase_q <= 1'b0;
    end else if (in_fire) begin
      if (!phase_q) begin
        first_q <= in_byte;
        phase_q <= 1'b1;
      end else begin
        word_q  <= swap ? {first_q, in_byte} : {in_byte, first_q};
        phase_q <= 1'b0;
      end
    end else if (ld_word) begin
      word_q  <= ld_data;
      phase_q <= 1'b0;
    end else if (out_fire) begin
      phase_q <= ~phase_q;
    end
  end

  assign out_byte = (phase_q ^ swap) ? word_q[WORD_W-1:BYTE_W] : word_q[BYTE_W-1:0];

  // R5/R6: packing and unpacking never run in the same cycle
  a_r5_one_path: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_fire && (ld_word || out_fire)));
endmodule

// File: rtl/blk_dma.sv
module blk_dma
  import blk_dma_pkg::*;
#(
  parameter int REG_W       = 32,
  parameter int LEN_W       = 16,
  parameter int BLK_BYTES   = 512,
  parameter int PAGE_BYTES  = 2048,
  parameter int RAM_AW      = 24,
  parameter int TMO_W       = 17,
  parameter int TMO_DEFAULT = 65536
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [3:0]        status,
  input  logic              tx_empty_i,
  input  logic              rx_full_i,
  input  logic              fin_valid,
  output logic              fin_ready,
  input  logic [7:0]        fin_data,
  input  logic              sd_valid,
  output logic              sd_ready,
  input  logic [7:0]        sd_data,
  output logic              fout_valid,
  input  logic              fout_ready,
  output logic [7:0]        fout_data,
  output logic              ram_req,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [15:0]       ram_wdata,
  input  logic              ram_ack,
  input  logic [15:0]       ram_rdata
);
  localparam int WPB_SH  = $clog2(BLK_BYTES / 2);
  localparam int PAGE_SH = $clog2(PAGE_BYTES / 2);
  localparam int BASE_W  = RAM_AW - PAGE_SH;
  localparam int CNT_W   = LEN_W + WPB_SH + 1;

  dma_st_e           state_q;
  dma_dir_e          dir_q;
  logic              swap_q;
  logic              tflag_q;
  logic [RAM_AW-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;

  logic [LEN_W-1:0]  len_q;
  logic [BASE_W-1:0] base_q;
  logic [TMO_W-1:0]  tmo_q;
  logic              start, start_swap;
  dma_dir_e          start_dir;
  logic              expired;
  logic [WORD_W-1:0] word_q;
  logic              phase_q;
  logic [BYTE_W-1:0] out_byte;

  logic busy, gather, src_valid, in_fire, ram_fire, out_fire, ld_word, progress, last_word;
  logic [BYTE_W-1:0] src_data;

  blk_dma_regs #(
    .REG_W(REG_W), .LEN_W(LEN_W), .BASE_W(BASE_W), .TMO_W(TMO_W), .TMO_DEFAULT(TMO_DEFAULT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata), .busy(busy),
    .len_q(len_q), .base_q(base_q), .tmo_q(tmo_q),
    .start(start), .start_dir(start_dir), .start_swap(start_swap)
  );

  blk_dma_stall #(.TMO_W(TMO_W)) u_stall (
    .clk(clk), .rst_n(rst_n), .active(busy), .progress(progress),
    .limit(tmo_q), .expired(expired)
  );

  blk_dma_lane u_lane (
    .clk(clk), .rst_n(rst_n), .clr(start), .swap(swap_q),
    .in_fire(in_fire), .in_byte(src_data),
    .ld_word(ld_word), .ld_data(ram_rdata),
    .out_fire(out_fire),
    .word_q(word_q), .phase_q(phase_q), .out_byte(out_byte)
  );

  assign busy      = (state_q != ST_IDLE);
  assign gather    = (state_q == ST_GATHER);
  assign src_valid = (dir_q == DIR_S2R) ? sd_valid : fin_valid;
  assign src_data  = (dir_q == DIR_S2R) ? sd_data  : fin_data;

  assign fin_ready = gather && (dir_q == DIR_F2R);
  assign sd_ready  = gather && (dir_q == DIR_S2R);
  assign in_fire   = gather && src_valid;

  assign ram_req   = (state_q == ST_WRITE) || (state_q == ST_FETCH);
  assign ram_we    = (state_q == ST_WRITE);
  assign ram_addr  = addr_q;
  assign ram_wdata = word_q;
  assign ram_fire  = ram_req && ram_ack;
  assign ld_word   = (state_q == ST_FETCH) && ram_ack;

  assign fout_valid = (state_q == ST_EMIT);
  assign fout_data  = out_byte;
  assign out_fire   = fout_valid && fout_ready;

  assign progress  = in_fire || ram_fire || out_fire;
  assign last_word = (left_q == CNT_W'(1));

  assign status = {rx_full_i, tx_empty_i, tflag_q, busy};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dir_q   <= DIR_NONE;
      swap_q  <= 1'b0;
      tflag_q <= 1'b0;
      addr_q  <= '0;
      left_q  <= '0;
    end else if (state_q == ST_IDLE) begin
      if (start) begin
        dir_q   <= start_dir;
        swap_q  <= start_swap;
        tflag_q <= 1'b0;
        addr_q  <= {base_q, {PAGE_SH{1'b0}}};
        left_q  <= (CNT_W'(len_q) + CNT_W'(1)) << WPB_SH;
        state_q <= (start_dir == DIR_R2F) ? ST_FETCH : ST_GATHER;
      end
    end else if (expired) begin
      state_q <= ST_IDLE;
      tflag_q <= 1'b1;
    end else begin
      case (state_q)
        ST_GATHER: if (in_fire && phase_q) state_q <= ST_WRITE;
        ST_WRITE: if (ram_ack) begin
          addr_q  <= addr_q + RAM_AW'(1);
          left_q  <= left_q - CNT_W'(1);
          state_q <= last_word ? ST_IDLE : ST_GATHER;
        end
        ST_FETCH: if (ram_ack) begin
          addr_q  <= addr_q + RAM_AW'(1);
          state_q <= ST_EMIT;
        end
        ST_EMIT: if (out_fire && phase_q) begin
          left_q  <= left_q - CNT_W'(1);
          state_q <= last_word ? ST_IDLE : ST_FETCH;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: a valid control write while idle raises busy on the next cycle
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == SEL_CTRL && reg_wdata[1:0] != 2'b00 && !status[0]) |=> status[0]);

  // R3: a running transfer always has words left to move
  a_r3_words_left: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (left_q != '0));

  // R4: each completed RAM access advances the address by one word
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    ram_fire |=> (ram_addr == $past(ram_addr) + RAM_AW'(1)));

  // R7: an offered output byte stays put until taken
  a_r7_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fout_valid && !fout_ready && !expired) |=> (fout_valid && $stable(fout_data)));

  // R8: RAM request is held steady until acknowledged
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_req && !ram_ack && !expired) |=>
      (ram_req && $stable(ram_addr) && $stable(ram_we) && $stable(ram_wdata)));

  // R9: the timeout flag is only ever shown while idle
  a_r9_flag_idle: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] |-> !status[0]);

  // R10: control writes during a transfer leave its settings alone
  a_r10_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && reg_sel == SEL_CTRL) |=> ($stable(dir_q) && $stable(swap_q)));
endmodule

// File: tb/blk_dma_tb.sv
`timescale 1ns/1ps
module blk_dma_tb;
  localparam int REG_W = 16;
  localparam int LEN_W = 3;
  localparam int BLKB  = 8;
  localparam int PAGEB = 16;
  localparam int AW    = 8;
  localparam int WPB   = BLKB / 2;
  localparam int PGW   = PAGEB / 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             reg_we = 1'b0;
  logic [1:0]       reg_sel = 2'd0;
  logic [REG_W-1:0] reg_wdata = '0;
  logic [3:0]       status;
  logic             tx_empty_i = 1'b0, rx_full_i = 1'b0;
  logic             fin_valid = 1'b0, fin_ready;
  logic [7:0]       fin_data = 8'd0;
  logic             sd_valid = 1'b0, sd_ready;
  logic [7:0]       sd_data = 8'd0;
  logic             fout_valid, fout_ready = 1'b0;
  logic [7:0]       fout_data;
  logic             ram_req, ram_we, ram_ack = 1'b0;
  logic [AW-1:0]    ram_addr;
  logic [15:0]      ram_wdata, ram_rdata = 16'd0;

  blk_dma #(
    .REG_W(REG_W), .LEN_W(LEN_W), .BLK_BYTES(BLKB), .PAGE_BYTES(PAGEB),
    .RAM_AW(AW), .TMO_W(8), .TMO_DEFAULT(40)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .status(status), .tx_empty_i(tx_empty_i), .rx_full_i(rx_full_i),
    .fin_valid(fin_valid), .fin_ready(fin_ready), .fin_data(fin_data),
    .sd_valid(sd_valid), .sd_ready(sd_ready), .sd_data(sd_data),
    .fout_valid(fout_valid), .fout_ready(fout_ready), .fout_data(fout_data),
    .ram_req(ram_req), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_ack(ram_ack), .ram_rdata(ram_rdata)
  );

  // settings owned by the main sequence
  int epoch = 0;
  int cur_base = 0, cur_seed = 0, cur_lat = 0, cur_sgap = 0, cur_kgap = 0, src_n = 0;
  bit cur_swap = 1'b0, src_on = 1'b0, src_sd = 1'b0, snk_on = 1'b0;
  int total = 0, bad = 0;

  function automatic logic [7:0] bpat(int i, int s);
    return 8'((i * 29 + s * 7 + 3) & 255);
  endfunction
  function automatic logic [15:0] wpat(int a, int s);
    return 16'((a * 613 + s * 11 + 5) & 65535);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // RAM model: responds on falling edges, checks every write it receives
  int wr_idx = 0, ram_seen = 0, wcnt = 0, ram_checks = 0, ram_bad = 0;
  always @(negedge clk) begin
    int k;
    logic [7:0] b0, b1;
    logic [15:0] ew;
    if (epoch != ram_seen) begin ram_seen = epoch; wr_idx = 0; end
    if (ram_ack) ram_ack = 1'b0;
    else if (ram_req) begin
      if (wcnt >= cur_lat) begin
        wcnt = 0;
        ram_ack = 1'b1;
        ram_rdata = wpat(int'(ram_addr), cur_seed);
        if (ram_we) begin
          k = wr_idx;
          b0 = bpat(2 * k, cur_seed);
          b1 = bpat(2 * k + 1, cur_seed);
          ew = cur_swap ? {b0, b1} : {b1, b0};
          ram_checks += 2;
          if (int'(ram_addr) != cur_base * PGW + k) begin
            ram_bad++;
            $display("FAIL R4 write address actual=%0h expected=%0h", ram_addr, cur_base * PGW + k);
          end
          if (ram_wdata != ew) begin
            ram_bad++;
            $display("FAIL R5 packed word actual=%0h expected=%0h", ram_wdata, ew);
          end
          wr_idx++;
        end
      end else wcnt++;
    end
  end

  // byte source for both inbound streams
  int src_idx = 0, src_seen = 0, src_tick = 0;
  always @(negedge clk) begin
    bit v;
    if (epoch != src_seen) begin src_seen = epoch; src_idx = 0; end
    src_tick++;
    v = src_on && (src_idx < src_n) && (cur_sgap == 0 || (src_tick % cur_sgap) != 0);
    fin_valid = v && !src_sd;
    sd_valid  = v && src_sd;
    fin_data  = bpat(src_idx, cur_seed);
    sd_data   = bpat(src_idx, cur_seed);
    if ((fin_valid && fin_ready) || (sd_valid && sd_ready)) src_idx++;
  end

  // byte sink for the outbound stream
  int snk_idx = 0, snk_seen = 0, snk_tick = 0, snk_checks = 0, snk_bad = 0;
  always @(negedge clk) begin
    logic [15:0] w;
    logic [7:0] eb;
    if (epoch != snk_seen) begin snk_seen = epoch; snk_idx = 0; end
    snk_tick++;
    fout_ready = snk_on && (cur_kgap == 0 || (snk_tick % cur_kgap) != 0);
    if (fout_valid && fout_ready) begin
      w  = wpat(cur_base * PGW + snk_idx / 2, cur_seed);
      eb = (((snk_idx % 2) == 1) ^ cur_swap) ? w[15:8] : w[7:0];
      snk_checks++;
      if (fout_data != eb) begin
        snk_bad++;
        $display("FAIL R6 byte %0d actual=%0h expected=%0h", snk_idx, fout_data, eb);
      end
      snk_idx++;
    end
  end

  task automatic wr(input logic [1:0] s, input int v);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = REG_W'(v);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (status[0] && n < 3000) begin @(negedge clk); n++; end
  endtask

  task automatic run_xfer(int dir, bit swp, int len, int base, int seed);
    int bytes = (len + 1) * BLKB;
    epoch++;
    cur_base = base; cur_swap = swp; cur_seed = seed;
    cur_lat = len % 3;
    cur_sgap = (len % 4 == 0) ? 0 : (len % 4) + 1;
    cur_kgap = swp ? 3 : 0;
    src_n = bytes; src_sd = (dir == 3); src_on = (dir != 2); snk_on = (dir == 2);
    wr(2'd0, len);
    wr(2'd1, base);
    wr(2'd2, {swp, 2'(dir)});
    chk(status[0] == 1'b1, "R2 busy after start", status[0], 1);
    if (dir == 1) chk(!sd_ready, "R7 unselected ready", sd_ready, 0);
    if (dir == 3) chk(!fin_ready, "R7 unselected ready", fin_ready, 0);
    if (dir == 2) chk(!fin_ready && !sd_ready, "R7 no input ready", fin_ready | sd_ready, 0);
    wait_idle();
    chk(status[1:0] == 2'b00, "R3 clean finish", status[1:0], 0);
    if (dir == 2) begin
      chk(snk_idx == bytes, "R3 bytes out", snk_idx, bytes);
      chk(wr_idx == 0, "R3 no writes on read", wr_idx, 0);
    end else begin
      chk(wr_idx == (len + 1) * WPB, "R3 words written", wr_idx, (len + 1) * WPB);
      chk(src_idx == bytes, "R3 bytes taken", src_idx, bytes);
    end
    src_on = 1'b0; snk_on = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  bit done = 1'b0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total + ram_checks + snk_checks + 1,
               bad + ram_bad + snk_bad + 1);
      $finish;
    end
  end

  initial begin
    int seed = 1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(status == 4'b0000, "R1 status", status, 0);
    chk(!ram_req && !fin_ready && !sd_ready && !fout_valid, "R1 quiet ports",
        {ram_req, fin_ready, sd_ready, fout_valid}, 0);

    // R11 status mirror, all four combinations
    for (int m = 0; m < 4; m++) begin
      tx_empty_i = m[0]; rx_full_i = m[1];
      @(negedge clk);
      chk(status[3:2] == 2'(m), "R11 level mirror", status[3:2], m);
    end
    tx_empty_i = 1'b0; rx_full_i = 1'b0;

    // R12 direction code 0 with swap set does not start
    wr(2'd2, 4);
    chk(status[0] == 1'b0 && !ram_req && !fin_ready, "R12 no start", status[0], 0);

    // sweep: every length, every direction, both byte orders
    for (int d = 1; d <= 3; d++)
      for (int s = 0; s < 2; s++)
        for (int l = 0; l < 8; l++) begin
          run_xfer(d, s[0], l, (l * 5 + d * 3 + s) % 24, seed);
          seed++;
        end

    // R9 timeout: source silent, limit 10
    epoch++;
    src_on = 1'b0; snk_on = 1'b0; cur_base = 3; cur_swap = 1'b0; cur_seed = seed;
    wr(2'd3, 10);
    wr(2'd0, 0);
    wr(2'd1, 3);
    wr(2'd2, 1);
    repeat (10) @(negedge clk);
    chk(status[1:0] == 2'b01, "R9 still busy at limit", status[1:0], 1);
    @(negedge clk);
    chk(status[1:0] == 2'b10, "R9 aborted with flag", status[1:0], 2);
    repeat (5) @(negedge clk);
    chk(status[1:0] == 2'b10 && !ram_req, "R9 flag held", status[1:0], 2);

    // R10: control write while busy is ignored; start also clears flag (R9)
    epoch++;
    seed++;
    cur_base = 2; cur_swap = 1'b1; cur_seed = seed; cur_lat = 1; cur_sgap = 0;
    src_n = BLKB; src_sd = 1'b0; src_on = 1'b0; snk_on = 1'b1; cur_kgap = 0;
    wr(2'd3, 40);
    wr(2'd1, 2);
    wr(2'd2, 5);
    chk(status[1:0] == 2'b01, "R9 flag cleared by start", status[1:0], 1);
    wr(2'd2, 2);
    chk(!ram_req && !fout_valid && fin_ready, "R10 direction kept",
        {ram_req, fout_valid, fin_ready}, 1);
    src_on = 1'b1;
    wait_idle();
    chk(wr_idx == WPB, "R10 words written", wr_idx, WPB);
    chk(snk_idx == 0, "R10 nothing sent out", snk_idx, 0);
    chk(status[1:0] == 2'b00, "R10 clean finish", status[1:0], 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total + ram_checks + snk_checks,
             bad + ram_bad + snk_bad);
    $finish;
  end
endmodule